// File: doc/BRIEF.md
# Supply Fault Alert Generator

This block sits between the fault detectors of a four-supply power controller and the shared interrupt line of the board. It keeps a twelve-bit fault register: one bit for each supply and each of three fault kinds (undervoltage, overcurrent, power-bad). From that register it decides when to pull an open-drain, active-low alert line. It also keeps an alert status bit that software can read.

An alert is raised only when a fault bit newly becomes set, its kind is enabled, and no other supply already has a fault of the same kind flagged. A fault that stays set never raises a second alert. Software ends an alert by writing zero to the status bit. The bus block can also end it with a strobe when this device wins an alert-response arbitration. Fault detection and the serial bus itself live elsewhere. Detector outputs arrive as levels, and register writes arrive as single-cycle strobes.

Top module: `fault_alert_gen`

## Requirements
- R1: After reset, the fault register, the kind enables and the status bit are all 0, and `alert_od_n` is 1 (released).
- R2: Fault bit index = kind*4 + supply, with kind 0 = undervoltage, 1 = overcurrent, 2 = power-bad. A high `fault_det` bit sets its flag at the next edge. The flag stays set until a `fault_clr` strobe for that bit arrives while its `fault_det` is low. If set and clear come in the same cycle, the set wins.
- R3: A flag that goes from 0 to 1, of an enabled kind, with no flag of that kind set on another supply, makes `alert_status` 1 at the same edge.
- R4: A new flag of a kind whose enable bit (`en_wdata` bit = kind, written with `en_we`) is 0 does not change `alert_status`.
- R5: A flag that stays set raises no further alert after the status has been cleared.
- R6: A new flag is ignored for alerting when a flag of the same kind is already set for any other supply.
- R7: A flag that is cleared and later set again raises a new alert.
- R8: A status write (`st_we`) with `st_wdata` = 0 clears `alert_status` at the next edge. A status write with `st_wdata` = 1 leaves it unchanged.
- R9: An `arp_win` strobe clears `alert_status` at the next edge.
- R10: If a qualifying new flag arrives in the same cycle as a status clear (either kind), `alert_status` is 1 after that edge.
- R11: `alert_od_n` is 0 exactly when `alert_status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_det | input | 12 | Detector requests to set fault flags |
| fault_clr | input | 12 | Per-bit flag clear strobes |
| en_we | input | 1 | Kind-enable register write strobe |
| en_wdata | input | 3 | Kind-enable write data, bit per kind |
| st_we | input | 1 | Status bit write strobe |
| st_wdata | input | 1 | Status bit write data |
| arp_win | input | 1 | Alert-response arbitration won |
| fault_flags | output | 12 | Current fault register |
| alert_en | output | 3 | Current kind enables |
| alert_status | output | 1 | Alert status bit |
| alert_od_n | output | 1 | Open-drain alert request, 0 = pull low |

## Verification
Two functions can land in the same cycle: raising the status for a new qualifying fault, and clearing it by a zero write or an arbitration win. Directed steps raise a fresh fault in the same cycle as each kind of clear, and the bench expects the status to read 1 afterwards. The random phase draws sparse fault requests together with frequent clear strobes, so these collisions recur. Each cycle is then judged against a bench model that gives the new fault priority.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
    localparam int unsigned DEF_NUM_SUPPLY = 4;
    localparam int unsigned DEF_NUM_KIND   = 3;

    typedef enum logic [1:0] {
        KIND_UNDERVOLT = 2'd0,
        KIND_OVERCURR  = 2'd1,
        KIND_PWR_BAD   = 2'd2
    } fault_kind_e;
endpackage

// File: rtl/fault_store.sv
module fault_store #(
    parameter int unsigned NUM_SUPPLY = 4,
    parameter int unsigned NUM_KIND   = 3,
    localparam int unsigned NUM_FLT   = NUM_SUPPLY * NUM_KIND
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLT-1:0] det_i,
    input  logic [NUM_FLT-1:0] clr_i,
    output logic [NUM_FLT-1:0] flags_q_o,
    output logic [NUM_FLT-1:0] rise_o
);
    logic [NUM_FLT-1:0] flags_d, flags_q;

    always_comb begin
        // a detector request outranks a clear strobe
        flags_d = (flags_q & ~clr_i) | det_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_q_o = flags_q;
    assign rise_o    = flags_d & ~flags_q;
endmodule

// File: rtl/alert_qualify.sv
module alert_qualify #(
    parameter int unsigned NUM_SUPPLY = 4,
    parameter int unsigned NUM_KIND   = 3,
    localparam int unsigned NUM_FLT   = NUM_SUPPLY * NUM_KIND
) (
    input  logic [NUM_FLT-1:0]  flags_q_i,
    input  logic [NUM_FLT-1:0]  rise_i,
    input  logic [NUM_KIND-1:0] kind_en_i,
    output logic                hit_o
);
    logic [NUM_FLT-1:0] qual;

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
        logic [NUM_SUPPLY-1:0] kind_flags;
        assign kind_flags = flags_q_i[k*NUM_SUPPLY +: NUM_SUPPLY];
        for (genvar s = 0; s < NUM_SUPPLY; s++) begin : g_sup
            logic [NUM_SUPPLY-1:0] others;
            localparam int unsigned IDX = k * NUM_SUPPLY + s;
            assign others    = kind_flags & ~(NUM_SUPPLY'(1) << s);
            assign qual[IDX] = rise_i[IDX] & kind_en_i[k] & ~(|others);
        end
    end

    assign hit_o = |qual;
endmodule

// File: rtl/fault_alert_gen.sv
module fault_alert_gen
    import fault_alert_pkg::*;
#(
    parameter int unsigned NUM_SUPPLY = DEF_NUM_SUPPLY,
    parameter int unsigned NUM_KIND   = DEF_NUM_KIND,
    localparam int unsigned NUM_FLT   = NUM_SUPPLY * NUM_KIND
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FLT-1:0]  fault_det,
    input  logic [NUM_FLT-1:0]  fault_clr,
    input  logic                en_we,
    input  logic [NUM_KIND-1:0] en_wdata,
    input  logic                st_we,
    input  logic                st_wdata,
    input  logic                arp_win,
    output logic [NUM_FLT-1:0]  fault_flags,
    output logic [NUM_KIND-1:0] alert_en,
    output logic                alert_status,
    output logic                alert_od_n
);
    typedef struct packed {
        logic [NUM_KIND-1:0] en;
        logic                status;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_FLT-1:0] flags_q, rise;
    logic qual_hit, clr_req;

    fault_store #(.NUM_SUPPLY(NUM_SUPPLY), .NUM_KIND(NUM_KIND)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_i    (fault_det),
        .clr_i    (fault_clr),
        .flags_q_o(flags_q),
        .rise_o   (rise)
    );

    alert_qualify #(.NUM_SUPPLY(NUM_SUPPLY), .NUM_KIND(NUM_KIND)) i_qual (
        .flags_q_i(flags_q),
        .rise_i   (rise),
        .kind_en_i(ctl_q.en),
        .hit_o    (qual_hit)
    );

    always_comb begin
        ctl_d   = ctl_q;
        clr_req = (st_we && !st_wdata) || arp_win;
        if (en_we) ctl_d.en = en_wdata;
        // new qualifying fault outranks any clear
        if (qual_hit)     ctl_d.status = 1'b1;
        else if (clr_req) ctl_d.status = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fault_flags  = flags_q;
    assign alert_en     = ctl_q.en;
    assign alert_status = ctl_q.status;
    assign alert_od_n   = ~ctl_q.status;
endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk #(
    parameter int unsigned NUM_FLT = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_FLT-1:0] fault_det,
    input logic [NUM_FLT-1:0] fault_flags,
    input logic               st_we,
    input logic               st_wdata,
    input logic               arp_win,
    input logic               qual_hit,
    input logic               alert_status,
    input logic               alert_od_n
);
    AST_DET_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault_flags & $past(fault_det)) == $past(fault_det))); // R2
    AST_ROSE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_status) |-> $past(qual_hit)); // R3
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !st_wdata && !qual_hit) |=> !alert_status); // R8
    AST_ARP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (arp_win && !qual_hit) |=> !alert_status); // R9
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        qual_hit |=> alert_status); // R10
    AST_PIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        alert_od_n == !alert_status); // R11
endmodule

bind fault_alert_gen fault_alert_chk #(.NUM_FLT(NUM_FLT)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_det   (fault_det),
    .fault_flags (fault_flags),
    .st_we       (st_we),
    .st_wdata    (st_wdata),
    .arp_win     (arp_win),
    .qual_hit    (qual_hit),
    .alert_status(alert_status),
    .alert_od_n  (alert_od_n)
);

// File: tb/test_fault_alert_gen.sv
module test_fault_alert_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] fault_det = '0, fault_clr = '0;
    logic        en_we = 1'b0, st_we = 1'b0, st_wdata = 1'b0, arp_win = 1'b0;
    logic [2:0]  en_wdata = '0;
    logic [11:0] fault_flags;
    logic [2:0]  alert_en;
    logic        alert_status, alert_od_n;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [11:0] m_flags = '0;
    logic [2:0]  m_en = '0;
    logic        m_st = 1'b0;

    always #5 clk = ~clk;

    fault_alert_gen i_fault_alert_gen (
        .clk(clk), .rst_n(rst_n), .fault_det(fault_det), .fault_clr(fault_clr),
        .en_we(en_we), .en_wdata(en_wdata), .st_we(st_we), .st_wdata(st_wdata),
        .arp_win(arp_win), .fault_flags(fault_flags), .alert_en(alert_en),
        .alert_status(alert_status), .alert_od_n(alert_od_n)
    );

    function automatic logic model_hit(logic [11:0] fl, logic [11:0] det,
                                       logic [11:0] clr, logic [2:0] en);
        logic [11:0] nxt = (fl & ~clr) | det;
        logic [11:0] rise = nxt & ~fl;
        logic hit = 1'b0;
        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 4; s++) begin
                logic [3:0] oth = fl[k*4 +: 4] & ~(4'b1 << s);
                if (rise[k*4+s] && en[k] && (oth == 4'b0)) hit = 1'b1;
            end
        return hit;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(logic [11:0] det, logic [11:0] clr, logic ew, logic [2:0] ed,
                        logic sw, logic sd, logic arp);
        logic hit;
        @(negedge clk);
        fault_det = det; fault_clr = clr; en_we = ew; en_wdata = ed;
        st_we = sw; st_wdata = sd; arp_win = arp;
        hit = model_hit(m_flags, det, clr, m_en);
        @(posedge clk);
        #1;
        if (hit) m_st = 1'b1;
        else if ((sw && !sd) || arp) m_st = 1'b0;
        m_flags = (m_flags & ~clr) | det;
        if (ew) m_en = ed;
        fault_det = '0; fault_clr = '0; en_we = 0; st_we = 0; arp_win = 0;
    endtask

    task automatic idle();
        step('0, '0, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (2) @(negedge clk);
        check("R1 flags", fault_flags, 0);
        check("R1 status", alert_status, 0);
        check("R1 pin", alert_od_n, 1);
        rst_n = 1'b1;
        idle();
        check("R1 enables", alert_en, 0);

        step('0, '0, 1, 3'b111, 0, 0, 0);
        check("R4 enable write", alert_en, 3'b111);
        step(12'h001, '0, 0, '0, 0, 0, 0);
        check("R2 flag set", fault_flags, 12'h001);
        check("R3 alert raised", alert_status, 1);
        check("R11 pin low", alert_od_n, 0);
        step('0, '0, 0, '0, 1, 1, 0);
        check("R8 write one keeps", alert_status, 1);
        step('0, '0, 0, '0, 1, 0, 0);
        check("R8 write zero clears", alert_status, 0);
        check("R11 pin released", alert_od_n, 1);
        repeat (3) step(12'h001, '0, 0, '0, 0, 0, 0);
        check("R5 held fault quiet", alert_status, 0);
        step(12'h002, '0, 0, '0, 0, 0, 0);
        check("R6 same kind suppressed", alert_status, 0);
        check("R2 second flag", fault_flags, 12'h003);
        step(12'h001, 12'h003, 0, '0, 0, 0, 0);
        check("R2 set wins over clear", fault_flags, 12'h001);
        step('0, 12'h001, 0, '0, 0, 0, 0);
        check("R2 clear", fault_flags, 12'h000);
        step(12'h001, '0, 0, '0, 0, 0, 0);
        check("R7 re-set alerts", alert_status, 1);
        step('0, '0, 0, '0, 0, 0, 1);
        check("R9 arp win clears", alert_status, 0);
        step('0, '0, 1, 3'b101, 0, 0, 0);
        step(12'h010, '0, 0, '0, 0, 0, 0);
        check("R4 disabled kind quiet", alert_status, 0);
        check("R4 flag still set", fault_flags, 12'h011);
        step('0, 12'hFFF, 0, '0, 0, 0, 0);
        step(12'h100, '0, 0, '0, 0, 0, 0);
        check("R3 power-bad alert", alert_status, 1);
        step(12'h008, '0, 0, '0, 1, 0, 0);
        check("R10 hit beats sw clear", alert_status, 1);
        step(12'h200, '0, 0, '0, 0, 0, 1);
        check("R10 hit suppressed, arp clears", alert_status, 0);
        step('0, 12'hFFF, 0, '0, 0, 0, 0);
        step(12'h400, '0, 0, '0, 0, 0, 1);
        check("R10 hit beats arp", alert_status, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [11:0] d = 12'($urandom & $urandom & $urandom);
            logic [11:0] c = 12'($urandom & $urandom);
            logic ew = ($urandom % 16) == 0;
            logic [2:0] ed = 3'($urandom);
            logic sw = ($urandom % 4) == 0;
            logic sd = 1'($urandom);
            logic arp = ($urandom % 6) == 0;
            step(d, c, ew, ed, sw, sd, arp);
            check("R2 random flags", fault_flags, m_flags);
            check("R3 random status", alert_status, m_st);
            check("R11 random pin", alert_od_n, !m_st);
            check("R4 random enables", alert_en, m_en);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule